// File: doc/BRIEF.md
# TFT Raster Timing Generator

This block produces the raster timing for a TFT panel from a set of configuration fields. It turns the system clock into a slower pixel clock. It walks a horizontal sequence of sync, back porch, active and front porch phases on each pixel tick, and a vertical sequence of the same four phases on each line. It drives the horizontal sync, vertical sync, data-enable and video data toward the panel. The current pixel and line position, a two-bit phase code for each axis and a down-counting line counter are available for software to read.

Each interval length is given as a field value; the interval always lasts one unit more than its field. The configuration fields are captured into shadow registers while the block is idle and again at the end of each frame. A change made in the middle of a frame therefore takes effect only on the next frame. The polarity controls act at once. When the enable is low, every panel output is held at 0 and the timing state returns to the start of a frame.

Top module: `lcd_raster_timer`

## Requirements
- R1: With divider field N, one pixel period lasts 2*(max(N,1)+1) system clocks, so a field of 0 behaves like 1. `pix_ce_o` is high only in the last system clock of each period. The non-inverted pixel clock is low for the first max(N,1)+1 clocks of the period and high for the rest.
- R2: The horizontal sequence repeats sync for `hsync_len_i`+1, back porch for `hback_i`+1, active for `hactive_i`+1 and front porch for `hfront_i`+1 pixel periods. The non-inverted `hsync_o` is 1 exactly during the sync phase.
- R3: The vertical sequence repeats sync, back porch, active and front porch for `vsync_len_i`+1, `vback_i`+1, `vactive_i`+1 and `vfront_i`+1 lines. It advances only at the end of a line, in the same cycle that the horizontal phase returns to sync. The non-inverted `vsync_o` is 1 exactly during vertical sync.
- R4: `hphase_o` and `vphase_o` encode the phase as 2'b00 sync, 2'b01 back porch, 2'b10 active and 2'b11 front porch.
- R5: During vertical active, `linecnt_o` equals `vactive_i` minus the active line index, so it counts down to 0 on the last active line. Outside vertical active it reads 0.
- R6: `xpos_o` gives the active pixel index (from 0) during horizontal active and 0 otherwise. `ypos_o` gives the active line index during vertical active and 0 otherwise.
- R7: The non-inverted `de_o` is 1 only when both axes are in the active phase. While it is 1, `data_o` equals `data_i`, or `~data_i` when `inv_data_i` is 1. Otherwise `data_o` is 0.
- R8: `inv_hsync_i`, `inv_vsync_i` and `inv_de_i` each invert their output. When `pclk_edge_i` is 1 the pixel clock is inverted. These controls take effect in the same cycle.
- R9: While `en_i` is 0, `pclk_o`, `pix_ce_o`, `hsync_o`, `vsync_o`, `de_o`, `data_o`, the positions, the phase codes and `linecnt_o` are all 0. After `en_i` rises, timing restarts at pixel 0 of line 0 of vertical sync.
- R10: Configuration inputs other than the polarity controls are captured when the block starts and at each frame end. A change made inside a frame has no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Video enable |
| clkdiv_i | input | DIV_W | Pixel clock divider field N |
| hsync_len_i | input | HSYNC_W | Horizontal sync length minus one |
| hback_i | input | HPORCH_W | Horizontal back porch minus one |
| hfront_i | input | HPORCH_W | Horizontal front porch minus one |
| hactive_i | input | HACT_W | Active pixels per line minus one |
| vsync_len_i | input | VSYNC_W | Vertical sync lines minus one |
| vback_i | input | VPORCH_W | Vertical back porch lines minus one |
| vfront_i | input | VPORCH_W | Vertical front porch lines minus one |
| vactive_i | input | VACT_W | Active lines per frame minus one |
| inv_hsync_i | input | 1 | Invert horizontal sync |
| inv_vsync_i | input | 1 | Invert vertical sync |
| inv_de_i | input | 1 | Invert data enable |
| inv_data_i | input | 1 | Invert video data |
| pclk_edge_i | input | 1 | Pixel clock edge select (1 inverts the clock) |
| data_i | input | DATA_W | Pixel data from the fetch path |
| pclk_o | output | 1 | Pixel clock to the panel |
| pix_ce_o | output | 1 | One-cycle pixel tick in the system domain |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| data_o | output | DATA_W | Video data to the panel |
| xpos_o | output | HACT_W | Active pixel index |
| ypos_o | output | VACT_W | Active line index |
| hphase_o | output | 2 | Horizontal phase code |
| vphase_o | output | 2 | Vertical phase code |
| linecnt_o | output | VACT_W | Down-counting active line counter |

## Verification
The bench checks every cycle of several small frames against a model that gets positions and phases only by division and remainder of the elapsed cycle count. An error of one in any interval length therefore shifts every later edge and is caught at once.

Three corner cases are targeted:
- A divider field of 0. A design that did not clamp it would tick every two clocks.
- Zero-valued sync and porch fields. A design that skipped such intervals would lose a whole phase code from the sequence.
- A configuration change in mid-frame, followed by a disable and re-enable in mid-frame. A design that loaded fields at once would bend the current frame. A design that kept its position across the disable would restart at the wrong pixel.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  // Phase codes shared by both axes; software decodes these values.
  typedef enum logic [1:0] {
    PH_SYNC   = 2'b00,
    PH_BACK   = 2'b01,
    PH_ACTIVE = 2'b10,
    PH_FRONT  = 2'b11
  } phase_e;

  // Advance to the next phase in raster order, wrapping front porch to sync.
  function automatic phase_e next_phase(input phase_e cur);
    logic [1:0] raw;
    raw = cur + 2'd1;
    return phase_e'(raw);
  endfunction

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] clkval,
  output logic             tick,
  output logic             pclk_raw
);

  // Effective divider: a field below 1 is clamped to 1.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  // Last count of a 2*(eff+1) period is 2*eff+1.
  function automatic logic [DIV_W:0] last_count(input logic [DIV_W-1:0] v);
    return {eff_div(v), 1'b1};
  endfunction

  logic [DIV_W:0] cnt;
  logic [DIV_W:0] last;
  logic [DIV_W:0] half;

  assign last = last_count(clkval);
  assign half = {1'b0, eff_div(clkval)};

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick     = run && (cnt == last);
  assign pclk_raw = run && (cnt > half);

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_raster_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  output phase_e       phase,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic [W-1:0] cur_len;
  logic         at_end;

  always_comb begin
    unique case (phase)
      PH_SYNC:   cur_len = len_sync;
      PH_BACK:   cur_len = len_back;
      PH_ACTIVE: cur_len = len_act;
      default:   cur_len = len_front;
    endcase
  end

  assign at_end = (cnt == cur_len);
  assign wrap   = step && at_end && (phase == PH_FRONT);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (at_end) begin
        phase <= next_phase(phase);
        cnt   <= '0;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int DIV_W    = 10,
  parameter int HSYNC_W  = 8,
  parameter int HPORCH_W = 8,
  parameter int HACT_W   = 11,
  parameter int VSYNC_W  = 6,
  parameter int VPORCH_W = 8,
  parameter int VACT_W   = 10,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [DIV_W-1:0]    clkdiv_i,
  input  logic [HSYNC_W-1:0]  hsync_len_i,
  input  logic [HPORCH_W-1:0] hback_i,
  input  logic [HPORCH_W-1:0] hfront_i,
  input  logic [HACT_W-1:0]   hactive_i,
  input  logic [VSYNC_W-1:0]  vsync_len_i,
  input  logic [VPORCH_W-1:0] vback_i,
  input  logic [VPORCH_W-1:0] vfront_i,
  input  logic [VACT_W-1:0]   vactive_i,
  input  logic                inv_hsync_i,
  input  logic                inv_vsync_i,
  input  logic                inv_de_i,
  input  logic                inv_data_i,
  input  logic                pclk_edge_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                pclk_o,
  output logic                pix_ce_o,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [HACT_W-1:0]   xpos_o,
  output logic [VACT_W-1:0]   ypos_o,
  output logic [1:0]          hphase_o,
  output logic [1:0]          vphase_o,
  output logic [VACT_W-1:0]   linecnt_o
);

  localparam int CFG_W = DIV_W + HSYNC_W + 2*HPORCH_W + HACT_W
                       + VSYNC_W + 2*VPORCH_W + VACT_W;

  // Shadow configuration, captured at start and at frame end.
  logic [DIV_W-1:0]    sh_div;
  logic [HSYNC_W-1:0]  sh_hs;
  logic [HPORCH_W-1:0] sh_hb;
  logic [HPORCH_W-1:0] sh_hf;
  logic [HACT_W-1:0]   sh_ha;
  logic [VSYNC_W-1:0]  sh_vs;
  logic [VPORCH_W-1:0] sh_vb;
  logic [VPORCH_W-1:0] sh_vf;
  logic [VACT_W-1:0]   sh_va;
  logic                run_q;

  // Named internal events.
  logic                pix_tick;
  logic                pclk_raw;
  logic                line_wrap;
  logic                frame_wrap;
  logic                shadow_load;
  logic [CFG_W-1:0]    cfg_bundle;
  phase_e              h_phase;
  phase_e              v_phase;
  logic [HACT_W-1:0]   h_cnt;
  logic [VACT_W-1:0]   v_cnt;
  logic                h_act;
  logic                v_act;
  logic                de_raw;

  assign shadow_load = !run_q || frame_wrap;
  assign cfg_bundle  = {sh_div, sh_hs, sh_hb, sh_hf, sh_ha,
                        sh_vs, sh_vb, sh_vf, sh_va};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sh_div <= '0;
      sh_hs  <= '0;
      sh_hb  <= '0;
      sh_hf  <= '0;
      sh_ha  <= '0;
      sh_vs  <= '0;
      sh_vb  <= '0;
      sh_vf  <= '0;
      sh_va  <= '0;
    end else begin
      run_q <= en_i;
      if (shadow_load) begin
        sh_div <= clkdiv_i;
        sh_hs  <= hsync_len_i;
        sh_hb  <= hback_i;
        sh_hf  <= hfront_i;
        sh_ha  <= hactive_i;
        sh_vs  <= vsync_len_i;
        sh_vb  <= vback_i;
        sh_vf  <= vfront_i;
        sh_va  <= vactive_i;
      end
    end
  end

  lcd_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_i),
    .clkval   (sh_div),
    .tick     (pix_tick),
    .pclk_raw (pclk_raw)
  );

  lcd_phase_seq #(.W(HACT_W)) u_hseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en_i),
    .step      (pix_tick),
    .len_sync  (HACT_W'(sh_hs)),
    .len_back  (HACT_W'(sh_hb)),
    .len_act   (sh_ha),
    .len_front (HACT_W'(sh_hf)),
    .phase     (h_phase),
    .cnt       (h_cnt),
    .wrap      (line_wrap)
  );

  lcd_phase_seq #(.W(VACT_W)) u_vseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en_i),
    .step      (line_wrap),
    .len_sync  (VACT_W'(sh_vs)),
    .len_back  (VACT_W'(sh_vb)),
    .len_act   (sh_va),
    .len_front (VACT_W'(sh_vf)),
    .phase     (v_phase),
    .cnt       (v_cnt),
    .wrap      (frame_wrap)
  );

  assign h_act  = (h_phase == PH_ACTIVE);
  assign v_act  = (v_phase == PH_ACTIVE);
  assign de_raw = h_act && v_act;

  // Panel outputs, forced to 0 while disabled.
  assign pclk_o   = en_i && (pclk_raw ^ pclk_edge_i);
  assign pix_ce_o = pix_tick;
  assign hsync_o  = en_i && ((h_phase == PH_SYNC) ^ inv_hsync_i);
  assign vsync_o  = en_i && ((v_phase == PH_SYNC) ^ inv_vsync_i);
  assign de_o     = en_i && (de_raw ^ inv_de_i);
  assign data_o   = (en_i && de_raw) ? (data_i ^ {DATA_W{inv_data_i}}) : '0;

  // Status outputs.
  assign xpos_o    = h_act ? h_cnt : '0;
  assign ypos_o    = v_act ? v_cnt : '0;
  assign hphase_o  = h_phase;
  assign vphase_o  = v_phase;
  assign linecnt_o = v_act ? (sh_va - v_cnt) : '0;

endmodule

// File: rtl/lcd_raster_timer_chk.sv
module lcd_raster_timer_chk #(
  parameter int HACT_W = 11,
  parameter int VACT_W = 10,
  parameter int CFG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              run_q,
  input logic              pix_tick,
  input logic              line_wrap,
  input logic              frame_wrap,
  input logic [1:0]        hph,
  input logic [1:0]        vph,
  input logic [HACT_W-1:0] hcnt,
  input logic [VACT_W-1:0] vcnt,
  input logic [VACT_W-1:0] sh_va,
  input logic [VACT_W-1:0] linecnt,
  input logic [CFG_W-1:0]  cfg,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic              pclk
);

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick |=> !pix_tick);

  // R2
  h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && !$past(pix_tick)) |-> ($stable(hcnt) && $stable(hph)));

  // R4
  h_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && (hph != $past(hph))) |-> (hph == 2'($past(hph) + 2'd1)));

  // R3
  v_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && (vph != $past(vph))) |-> ($past(line_wrap) && hph == 2'b00));

  // R5
  linecnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vph == 2'b10) |-> (linecnt <= sh_va));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!hsync && !vsync && !de && !pclk && !pix_tick));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !$past(frame_wrap)) |-> $stable(cfg));

endmodule

bind lcd_raster_timer lcd_raster_timer_chk #(
  .HACT_W (HACT_W),
  .VACT_W (VACT_W),
  .CFG_W  (CFG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en_i),
  .run_q      (run_q),
  .pix_tick   (pix_tick),
  .line_wrap  (line_wrap),
  .frame_wrap (frame_wrap),
  .hph        (h_phase),
  .vph        (v_phase),
  .hcnt       (h_cnt),
  .vcnt       (v_cnt),
  .sh_va      (sh_va),
  .linecnt    (linecnt_o),
  .cfg        (cfg_bundle),
  .hsync      (hsync_o),
  .vsync      (vsync_o),
  .de         (de_o),
  .pclk       (pclk_o)
);

// File: tb/lcd_raster_timer_tb.sv
module lcd_raster_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [9:0]  clkdiv_i = '0;
  logic [7:0]  hsync_len_i = '0;
  logic [7:0]  hback_i = '0;
  logic [7:0]  hfront_i = '0;
  logic [10:0] hactive_i = '0;
  logic [5:0]  vsync_len_i = '0;
  logic [7:0]  vback_i = '0;
  logic [7:0]  vfront_i = '0;
  logic [9:0]  vactive_i = '0;
  logic        inv_hsync_i = 1'b0;
  logic        inv_vsync_i = 1'b0;
  logic        inv_de_i = 1'b0;
  logic        inv_data_i = 1'b0;
  logic        pclk_edge_i = 1'b0;
  logic [15:0] data_i = '0;

  logic        pclk_o, pix_ce_o, hsync_o, vsync_o, de_o;
  logic [15:0] data_o;
  logic [10:0] xpos_o;
  logic [9:0]  ypos_o, linecnt_o;
  logic [1:0]  hphase_o, vphase_o;

  always #2.5 clk = ~clk;

  lcd_raster_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .clkdiv_i(clkdiv_i),
    .hsync_len_i(hsync_len_i), .hback_i(hback_i), .hfront_i(hfront_i),
    .hactive_i(hactive_i), .vsync_len_i(vsync_len_i), .vback_i(vback_i),
    .vfront_i(vfront_i), .vactive_i(vactive_i), .inv_hsync_i(inv_hsync_i),
    .inv_vsync_i(inv_vsync_i), .inv_de_i(inv_de_i), .inv_data_i(inv_data_i),
    .pclk_edge_i(pclk_edge_i), .data_i(data_i), .pclk_o(pclk_o),
    .pix_ce_o(pix_ce_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .data_o(data_o), .xpos_o(xpos_o), .ypos_o(ypos_o), .hphase_o(hphase_o),
    .vphase_o(vphase_o), .linecnt_o(linecnt_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Model state: configuration of the frame in progress.
  int a_div, a_hs, a_hb, a_ha, a_hf, a_vs, a_vb, a_va, a_vf;
  longint t_cyc, base;
  bit cfg_switched;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t_cyc, act, exp);
    end
  endtask

  task automatic latch_cfg();
    a_div = int'(clkdiv_i); a_hs = int'(hsync_len_i); a_hb = int'(hback_i);
    a_ha = int'(hactive_i); a_hf = int'(hfront_i); a_vs = int'(vsync_len_i);
    a_vb = int'(vback_i); a_va = int'(vactive_i); a_vf = int'(vfront_i);
  endtask

  // Phase and index within a four-interval sequence, each interval field+1.
  function automatic void seg(input int pos, input int s, input int b,
                              input int a, output int ph, output int idx);
    if (pos < s + 1) begin
      ph = 0; idx = pos;
    end else if (pos < s + b + 2) begin
      ph = 1; idx = pos - s - 1;
    end else if (pos < s + b + a + 3) begin
      ph = 2; idx = pos - s - b - 2;
    end else begin
      ph = 3; idx = pos - s - b - a - 3;
    end
  endfunction

  task automatic check_sample();
    int eff, dlen, llen, flen, p, dv, hpos, vln, hph, hix, vph, vix;
    longint fc, rel;
    bit e_hs, e_vs, e_de;
    longint e_data, e_x, e_y, e_lc;
    eff  = (a_div == 0) ? 1 : a_div;
    dlen = 2 * (eff + 1);
    llen = a_hs + a_hb + a_ha + a_hf + 4;
    flen = a_vs + a_vb + a_va + a_vf + 4;
    fc   = longint'(dlen) * llen * flen;
    if (t_cyc - base >= fc) begin
      base = base + fc;
      latch_cfg();
      eff  = (a_div == 0) ? 1 : a_div;
      dlen = 2 * (eff + 1);
      llen = a_hs + a_hb + a_ha + a_hf + 4;
      flen = a_vs + a_vb + a_va + a_vf + 4;
    end
    rel  = t_cyc - base;
    p    = int'(rel / dlen);
    dv   = int'(rel % dlen);
    hpos = p % llen;
    vln  = (p / llen) % flen;
    seg(hpos, a_hs, a_hb, a_ha, hph, hix);
    seg(vln, a_vs, a_vb, a_va, vph, vix);
    e_hs   = (hph == 0) ^ inv_hsync_i;
    e_vs   = (vph == 0) ^ inv_vsync_i;
    e_de   = ((hph == 2) && (vph == 2)) ^ inv_de_i;
    e_data = ((hph == 2) && (vph == 2)) ?
             longint'(data_i ^ {16{inv_data_i}}) : 0;
    e_x    = (hph == 2) ? hix : 0;
    e_y    = (vph == 2) ? vix : 0;
    e_lc   = (vph == 2) ? (a_va - vix) : 0;
    // R1: divider timing and tick
    chk("R1", {pclk_o, pix_ce_o},
        {((dv > eff) ^ pclk_edge_i), (dv == dlen - 1)});
    chk("R2", hsync_o, e_hs);
    chk("R3", vsync_o, e_vs);
    chk("R4", {hphase_o, vphase_o}, {2'(hph), 2'(vph)});
    chk("R5", linecnt_o, e_lc);
    chk("R6", {xpos_o, ypos_o}, {11'(e_x), 10'(e_y)});
    chk("R7", {de_o, data_o}, {e_de, 16'(e_data)});
    if (inv_hsync_i || inv_vsync_i || inv_de_i || pclk_edge_i)
      chk("R8", {pclk_o, hsync_o, vsync_o, de_o},
          {((dv > eff) ^ pclk_edge_i), e_hs, e_vs, e_de});
    if (cfg_switched)
      chk("R10", {hphase_o, vphase_o, ypos_o}, {2'(hph), 2'(vph), 10'(e_y)});
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_cyc++;
      check_sample();
      data_i = 16'($urandom);
    end
  endtask

  task automatic start_run();
    @(negedge clk);
    en_i = 1'b1;
    t_cyc = 0;
    base = 0;
    latch_cfg();
  endtask

  task automatic set_cfg(input int dv, input int hs, input int hb, input int ha,
                         input int hf, input int vs, input int vb, input int va,
                         input int vf);
    clkdiv_i = 10'(dv); hsync_len_i = 8'(hs); hback_i = 8'(hb);
    hactive_i = 11'(ha); hfront_i = 8'(hf); vsync_len_i = 6'(vs);
    vback_i = 8'(vb); vactive_i = 10'(va); vfront_i = 8'(vf);
  endtask

  task automatic check_idle(input string req);
    chk(req, {pclk_o, pix_ce_o, hsync_o, vsync_o, de_o, data_o, xpos_o,
              ypos_o, hphase_o, vphase_o, linecnt_o}, 0);
  endtask

  initial begin
    cfg_switched = 1'b0;
    t_cyc = 0;
    base = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    data_i = 16'h5AA5;
    check_idle("R9");

    // Zero-length sync and porch fields, plain polarity.
    set_cfg(1, 0, 1, 3, 0, 0, 0, 2, 1);
    start_run();
    run_cycles(500);

    // Divider field 0 clamps to 1; all inversions active.
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); check_idle("R9");
    set_cfg(0, 2, 0, 4, 1, 1, 1, 3, 0);
    inv_hsync_i = 1'b1; inv_vsync_i = 1'b1; inv_de_i = 1'b1;
    inv_data_i = 1'b1; pclk_edge_i = 1'b1;
    start_run();
    run_cycles(900);

    // Mid-frame configuration change.
    @(negedge clk); en_i = 1'b0;
    inv_hsync_i = 1'b0; inv_vsync_i = 1'b0; inv_de_i = 1'b0;
    inv_data_i = 1'b0; pclk_edge_i = 1'b0;
    @(negedge clk); check_idle("R9");
    set_cfg(2, 1, 2, 2, 2, 0, 1, 1, 0);
    start_run();
    run_cycles(150);
    set_cfg(1, 0, 1, 3, 0, 0, 0, 2, 1);
    cfg_switched = 1'b1;
    run_cycles(700);
    cfg_switched = 1'b0;

    // Disable in mid-frame, then restart from the frame origin.
    @(negedge clk); en_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_idle("R9");
    end
    set_cfg(1, 1, 0, 2, 1, 0, 1, 1, 0);
    start_run();
    run_cycles(400);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule